// File: doc/BRIEF.md
# Two-Dimensional Parity Block Codec

This block protects short groups of 7-bit characters with parity in two directions. In encode mode it takes each character, adds an even-parity bit in the top position to form a byte, and sends that byte out one cycle later. While a group is open it keeps a running per-column parity. When the group closes it sends one extra check byte. This byte holds the column parity of every bit position and carries its own even-parity bit.

In check mode the same block receives a finished group of bytes and checks them. The data bytes come first, and the last byte, marked end-of-group, is the check byte. Each received byte is echoed on the output. A row flag marks any byte with an odd count of ones. A column flag, given alongside the check byte, marks a check byte that does not match the column parity recomputed over the group's data bytes. Groups are framed by start-of-group and end-of-group markers that travel with the characters. Characters are accepted under a valid/ready handshake.

Top module: `grid_parity_codec`

## Requirements
- R1: While reset is held and after it is released, out_valid, row_err and col_err are 0 and in_ready is 1.
- R2: In encode mode (mode_check=0), a character accepted at a clock edge appears on out_byte with out_valid=1 in the following cycle. Bits 6..0 hold the character and bit 7 is the even-parity bit, 1 exactly when bits 6..0 hold an odd number of ones.
- R3: In encode mode, the check byte's bits 6..0 are, for each position, the XOR of that bit over all characters of the group. The group starts at the character marked in_sog, which clears the running parity. Bit 7 of the check byte is the even-parity bit of its own bits 6..0.
- R4: In encode mode, the check byte appears with out_valid=1 and out_chk=1 in the cycle directly after the last data byte of the group, which is the one accepted with in_eog.
- R5: In encode mode, in_ready is 0 for exactly the one cycle following acceptance of an in_eog character, and 1 otherwise, so no character is taken while the check byte is being formed.
- R6: In check mode (mode_check=1), in_ready stays 1. Each accepted byte is echoed on out_byte in the next cycle with out_valid=1. row_err is 1 in that cycle exactly when the byte has an odd count of ones.
- R7: In check mode, the byte accepted with in_eog is the check byte and is echoed with out_chk=1. col_err is 1 in that cycle exactly when it differs from the XOR of the group's data bytes taken since in_sog. col_err is 0 in every other cycle.
- R8: In check mode, one flipped bit in a data byte raises row_err for that byte. Two flipped bits in one byte leave row_err at 0, but they do raise col_err on the check byte.
- R9: In encode mode, in_data bit 7 has no effect on any output, and row_err and col_err stay 0.
- R10: A character marked with both in_sog and in_eog forms a group of one. Its check byte equals its own encoded byte.
- R11: Cycles with in_valid=0 inside a group produce no output (out_valid=0) and leave the column parity unchanged, so gaps do not alter the check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_check | input | 1 | 0 = encode groups, 1 = check received groups; held steady while a group is open |
| in_valid | input | 1 | Character or byte offered on in_data |
| in_ready | output | 1 | Block can accept in this cycle |
| in_sog | input | 1 | Offered item opens a group |
| in_eog | input | 1 | Offered item closes a group (in check mode: it is the check byte) |
| in_data | input | 8 | Encode: character in bits 6..0; check: full received byte |
| out_valid | output | 1 | out_byte and flags are meaningful this cycle |
| out_byte | output | 8 | Encoded byte, check byte, or echoed received byte |
| out_chk | output | 1 | out_byte is the group check byte |
| row_err | output | 1 | Check mode: echoed byte has odd parity |
| col_err | output | 1 | Check mode: check byte disagrees with recomputed column parity |

## Verification
A wrong column accumulator does not show up at once. It appears only on the group's check byte, or on col_err, which can be a whole group length after the fault. Groups of one, groups with idle gaps, and back-to-back groups are all used, so that a failure to clear or a spurious update is exposed within the next group. A stuck pending-check flag shows up in the very next cycle, as a wrong in_ready or a missing or repeated out_chk byte. A wrong row parity shows up on the first byte that follows, because every output is compared against the reference model on every clock.

// File: rtl/grid_parity_pkg.sv
package grid_parity_pkg;

    // Width of one data character; the coded byte is one bit wider.
    parameter int GP_DATA_W = 7;

    typedef enum logic {
        GP_ENCODE = 1'b0,
        GP_CHECK  = 1'b1
    } gp_mode_e;

endpackage

// File: rtl/gp_row_parity.sv
module gp_row_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits,
    output logic         odd
);

    // Reduction by chained XOR over the word; 1 means an odd count of ones.
    always_comb begin
        odd = 1'b0;
        for (int i = 0; i < W; i++) begin
            odd = odd ^ bits[i];
        end
    end

endmodule

// File: rtl/gp_col_accum.sv
module gp_col_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_grp,
    input  logic         take,
    input  logic         close_grp,
    input  logic [W-1:0] din,
    output logic [W-1:0] base
);

    logic [W-1:0] acc_d, acc_q;

    // Running column parity seen by the current item: a group opener starts from zero.
    assign base = open_grp ? '0 : acc_q;

    always_comb begin
        acc_d = acc_q;
        if (close_grp) begin
            acc_d = '0;
        end else if (take) begin
            acc_d = base ^ din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/grid_parity_codec.sv
module grid_parity_codec
    import grid_parity_pkg::*;
#(
    parameter int DATA_W = GP_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_check,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sog,
    input  logic              in_eog,
    input  logic [DATA_W:0]   in_data,
    output logic              out_valid,
    output logic [DATA_W:0]   out_byte,
    output logic              out_chk,
    output logic              row_err,
    output logic              col_err
);

    localparam int BYTE_W = DATA_W + 1;

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] pend_byte;
        logic              out_valid;
        logic [BYTE_W-1:0] out_byte;
        logic              out_chk;
        logic              row_err;
        logic              col_err;
    } state_t;

    state_t st_d, st_q;

    gp_mode_e          mode;
    logic              accept;
    logic              chr_odd;
    logic              rx_odd;
    logic [BYTE_W-1:0] enc_byte;
    logic [BYTE_W-1:0] acc_din;
    logic [BYTE_W-1:0] col_base;
    logic              acc_take;
    logic              acc_close;

    assign mode     = gp_mode_e'(mode_check);
    assign in_ready = (mode == GP_CHECK) || !st_q.pend;
    assign accept   = in_valid && in_ready;

    // Row parity of the bare character (encode) and of the whole received byte (check).
    gp_row_parity #(.W(DATA_W)) u_chr_par (
        .bits (in_data[DATA_W-1:0]),
        .odd  (chr_odd)
    );

    gp_row_parity #(.W(BYTE_W)) u_rx_par (
        .bits (in_data),
        .odd  (rx_odd)
    );

    assign enc_byte  = {chr_odd, in_data[DATA_W-1:0]};
    assign acc_din   = (mode == GP_CHECK) ? in_data : enc_byte;
    assign acc_take  = accept && !((mode == GP_CHECK) && in_eog);
    assign acc_close = accept && in_eog;

    gp_col_accum #(.W(BYTE_W)) u_cols (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_grp  (in_sog),
        .take      (acc_take),
        .close_grp (acc_close),
        .din       (acc_din),
        .base      (col_base)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.out_chk   = 1'b0;
        st_d.row_err   = 1'b0;
        st_d.col_err   = 1'b0;
        case (mode)
            GP_ENCODE: begin
                if (st_q.pend) begin
                    st_d.out_valid = 1'b1;
                    st_d.out_byte  = st_q.pend_byte;
                    st_d.out_chk   = 1'b1;
                    st_d.pend      = 1'b0;
                end else if (accept) begin
                    st_d.out_valid = 1'b1;
                    st_d.out_byte  = enc_byte;
                    if (in_eog) begin
                        // Column parity including this last byte; its top bit is
                        // automatically the even parity of the lower bits.
                        st_d.pend      = 1'b1;
                        st_d.pend_byte = col_base ^ enc_byte;
                    end
                end
            end
            default: begin
                st_d.pend = 1'b0;
                if (accept) begin
                    st_d.out_valid = 1'b1;
                    st_d.out_byte  = in_data;
                    st_d.row_err   = rx_odd;
                    if (in_eog) begin
                        st_d.out_chk = 1'b1;
                        st_d.col_err = (in_data != col_base);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_byte  = st_q.out_byte;
    assign out_chk   = st_q.out_chk;
    assign row_err   = st_q.row_err;
    assign col_err   = st_q.col_err;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_check && in_valid && in_ready && in_eog) |=> !in_ready); // R5

    AST_CHECK_BYTE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_check && in_valid && in_ready && in_eog) |=> ##1 (out_valid && out_chk)); // R4

    AST_ENC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(mode_check)) |-> ($countones(out_byte) % 2 == 0)); // R2

    AST_COL_ON_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        col_err |-> (out_valid && out_chk)); // R7

    AST_ENC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_check) |-> !(row_err || col_err)); // R9

endmodule

// File: tb/sim_grid_parity_codec.sv
`timescale 1ns/1ps
module sim_grid_parity_codec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_check = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sog = 1'b0;
    logic       in_eog = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_chk;
    logic       row_err;
    logic       col_err;

    grid_parity_codec u0 (
        .clk(clk), .rst_n(rst_n), .mode_check(mode_check),
        .in_valid(in_valid), .in_ready(in_ready), .in_sog(in_sog), .in_eog(in_eog),
        .in_data(in_data), .out_valid(out_valid), .out_byte(out_byte),
        .out_chk(out_chk), .row_err(row_err), .col_err(col_err)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit         m_pend = 0;
    logic [7:0] m_pend_byte = '0;
    logic [7:0] m_acc = '0;
    bit         m_valid = 0, m_chk = 0, m_row = 0, m_col = 0;
    logic [7:0] m_byte = '0;

    logic [7:0] last_chk = '0;
    logic [7:0] last_dat = '0;
    int row_hits = 0;
    int col_hits = 0;

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit odd_ones(input logic [7:0] v);
        return ($countones(v) % 2) == 1;
    endfunction

    task automatic step(input bit v, input bit sog, input bit eog, input logic [7:0] d, output bit took);
        bit m_ready;
        logic [7:0] b, base;
        in_valid = v; in_sog = sog; in_eog = eog; in_data = d;
        m_ready = mode_check ? 1'b1 : !m_pend;
        #0;
        check(in_ready === m_ready, "R5 in_ready", {7'd0, in_ready}, {7'd0, m_ready});
        took = v && m_ready;
        @(posedge clk);
        m_valid = 0; m_chk = 0; m_row = 0; m_col = 0;
        if (!mode_check) begin
            if (m_pend) begin
                m_valid = 1; m_chk = 1; m_byte = m_pend_byte; m_pend = 0;
            end else if (took) begin
                b = {odd_ones({1'b0, d[6:0]}), d[6:0]};
                if (sog) m_acc = '0;
                m_acc = m_acc ^ b;
                m_valid = 1; m_byte = b;
                if (eog) begin
                    m_pend = 1; m_pend_byte = m_acc; m_acc = '0;
                end
            end
        end else begin
            m_pend = 0;
            if (took) begin
                base = sog ? 8'h00 : m_acc;
                m_valid = 1; m_byte = d; m_row = odd_ones(d);
                if (eog) begin
                    m_chk = 1; m_col = (d != base); m_acc = '0;
                end else begin
                    m_acc = base ^ d;
                end
            end
        end
        @(negedge clk);
        check(out_valid === m_valid, "R11 out_valid", {7'd0, out_valid}, {7'd0, m_valid});
        if (m_valid) begin
            check(out_byte === m_byte, "R2 out_byte", out_byte, m_byte);
            check(out_chk === m_chk, "R4 out_chk", {7'd0, out_chk}, {7'd0, m_chk});
            check(row_err === m_row, "R6 row_err", {7'd0, row_err}, {7'd0, m_row});
            check(col_err === m_col, "R7 col_err", {7'd0, col_err}, {7'd0, m_col});
        end else begin
            check(!row_err && !col_err, "R9 idle flags", {6'd0, row_err, col_err}, 8'h00);
        end
        if (out_valid && out_chk) last_chk = out_byte;
        if (out_valid && !out_chk) last_dat = out_byte;
        if (out_valid && row_err) row_hits++;
        if (out_valid && col_err) col_hits++;
    endtask

    task automatic send(input bit sog, input bit eog, input logic [7:0] d);
        bit t;
        t = 0;
        while (!t) step(1'b1, sog, eog, d, t);
    endtask

    task automatic idle(input int n);
        bit t;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, t);
    endtask

    task automatic rx_group(input logic [7:0] b1, input logic [7:0] ck);
        row_hits = 0; col_hits = 0;
        send(1, 0, 8'h48); send(0, 0, b1); send(0, 0, 8'hCC);
        send(0, 0, 8'hCC); send(0, 0, 8'hCF); send(0, 1, ck);
        idle(2);
    endtask

    initial begin
        bit t;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && row_err === 1'b0 && col_err === 1'b0, "R1 reset outputs",
              {5'd0, out_valid, row_err, col_err}, 8'h00);
        check(in_ready === 1'b1, "R1 reset ready", {7'd0, in_ready}, 8'h01);
        rst_n = 1'b1;
        idle(1);

        // Encode, back to back; column parity of this set is 0x42
        send(1, 0, 8'h48); send(0, 0, 8'h45); send(0, 0, 8'h4C); send(0, 0, 8'h4C); send(0, 1, 8'h4F);
        step(1, 0, 0, 8'h11, t);   // R5: offered during check byte slot, must not be taken
        check(t == 0, "R5 blocked offer", {7'd0, t}, 8'h00);
        idle(2);
        check(last_chk === 8'h42, "R3 check byte", last_chk, 8'h42);

        // Same group with idle gaps
        send(1, 0, 8'h48); idle(1); send(0, 0, 8'h45); idle(2); send(0, 0, 8'h4C);
        idle(1); send(0, 0, 8'h4C); idle(3); send(0, 1, 8'h4F);
        idle(2);
        check(last_chk === 8'h42, "R11 gaps keep check byte", last_chk, 8'h42);

        // Group of one, with bit 7 set on input (ignored)
        send(1, 1, 8'hC8);
        idle(2);
        check(last_dat === 8'h48, "R9 top input bit ignored", last_dat, 8'h48);
        check(last_chk === 8'h48, "R10 single-item group", last_chk, 8'h48);

        // Two all-ones characters, immediately followed by another group
        send(1, 0, 8'h7F); send(0, 1, 8'h7F);
        send(1, 1, 8'h01);
        idle(2);
        check(last_chk === 8'h81, "R3 back-to-back group", last_chk, 8'h81);

        // Check mode
        idle(2);
        mode_check = 1'b1;
        idle(2);
        rx_group(8'hC5, 8'h42);
        check(row_hits == 0, "R6 clean rows", row_hits[7:0], 8'h00);
        check(col_hits == 0, "R7 clean columns", col_hits[7:0], 8'h00);
        rx_group(8'hC4, 8'h42);
        check(row_hits == 1, "R8 single flip row", row_hits[7:0], 8'h01);
        check(col_hits == 1, "R7 single flip column", col_hits[7:0], 8'h01);
        rx_group(8'hC6, 8'h42);
        check(row_hits == 0, "R8 double flip passes row", row_hits[7:0], 8'h00);
        check(col_hits == 1, "R8 double flip caught by column", col_hits[7:0], 8'h01);
        rx_group(8'hC5, 8'hC2);
        check(row_hits == 1, "R6 corrupt check byte row", row_hits[7:0], 8'h01);
        check(col_hits == 1, "R7 corrupt check byte column", col_hits[7:0], 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule